// File: doc/BRIEF.md
# Interrupt Distributor State Bank

This block keeps the per-interrupt bookkeeping of an interrupt distributor for `NUM_IRQ` sources: enable, pending, stored input level, model and trigger configuration, an 8-bit priority and an 8-bit target byte. Interrupts 0 to 31 have no wire input. Each external request line `n` feeds interrupt `n + 32`. A rising line sets pending when the interrupt is edge-triggered or enabled.

Software reaches the state through a byte-addressed access port with a 12-bit offset. Enable and pending bits each have a write-one-to-set range and a write-one-to-clear range. Priority, target and configuration bytes can be read and written. A read-only range shows the active flags supplied by the CPU side. A 10-bit software-trigger write sets pending for any interrupt number, and identification bytes can be read. Read data and the error flag are combinational in the access cycle. Writes commit at the next clock edge.

The enable vector, the pending vector, the priorities and the global enable go straight to a priority arbiter. The arbiter sees each change in the cycle after the edge that commits it.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset, interrupts 0 to 14 are enabled and edge-triggered, and every other per-interrupt bit is 0. The global enable (`dist_en`) is 0 and all priorities and targets are 0.
- R2: External line n drives interrupt n+32. A 0-to-1 change on the line sets that interrupt's pending bit when the interrupt is edge-triggered or enabled. Otherwise the change sets nothing.
- R3: A 1-to-0 change, or a line held at one value, never changes the pending bit. Only the stored level is updated.
- R4: A write to 0x100+b sets the enable of interrupt 8b+k for each data bit k that is 1. A write to 0x180+b clears it for each data bit k that is 1. Data bits that are 0 have no effect. Both ranges read back the enable bits.
- R5: Setting the enable of a level-triggered interrupt whose line is high also sets its pending bit.
- R6: Writes to 0x200+b set pending bits and writes to 0x280+b clear them, using the same bit mapping as R4. Both ranges read back the pending bits. A clear wins over a rising-line set in the same cycle.
- R7: Reads of 0x300+b return the `act_flags` bits of interrupts 8b..8b+7. Any write to 0x300-0x3FF raises `acc_err` and changes nothing.
- R8: Byte 0x400+n holds the priority of interrupt n and byte 0x800+n holds its target. Both can be read and written. The priority appears on `irq_prio[8n +: 8]`.
- R9: Byte 0xC00+m configures interrupts 4m..4m+3. Data bit 2j is the model bit of interrupt 4m+j and bit 2j+1 selects edge trigger (1) or level trigger (0). The byte reads back as written.
- R10: A wide write to 0xF00 sets the pending bit of interrupt `acc_wdata[9:0]`. A number at or above NUM_IRQ raises `acc_err` and changes nothing.
- R11: Bit 0 of offset 0x000 is the global enable and is readable. Offsets 0x001-0x003 read 0 and ignore writes. 0x004 reads NUM_IRQ/32-1. 0x005-0x007 read 0.
- R12: A read of 0xFE0+4k returns byte k (bits 8k+7..8k) of parameter IDENT. Other bytes in 0xFE0-0xFFF read 0.
- R13: These accesses raise `acc_err` in their own cycle and change no state:
  - a read of 0x008-0x0FF;
  - a write of 0x004-0x0FF;
  - an interrupt index at or beyond NUM_IRQ;
  - a byte access to 0xF00-0xFDF;
  - a write to 0xFE0-0xFFF;
  - a wide access other than a write to 0xF00.
- R14: Enable and pending outputs change only at a clock edge. An accepted write shows on the outputs after the edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lvl | input | NUM_IRQ-32 | External request lines, line n feeds interrupt n+32 |
| act_flags | input | NUM_IRQ | Active flags from the CPU side, read-only view |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | Wide access (software trigger only) |
| acc_addr | input | 12 | Byte offset |
| acc_wdata | input | 10 | Write data; byte accesses use bits 7:0 |
| acc_rdata | output | 8 | Read data, combinational |
| acc_err | output | 1 | Unmapped or illegal access, combinational |
| dist_en | output | 1 | Global distributor enable |
| irq_en | output | NUM_IRQ | Enable vector to arbiter |
| irq_pend | output | NUM_IRQ | Pending vector to arbiter |
| irq_prio | output | 8*NUM_IRQ | Priorities, 8 bits per interrupt |

## Verification
The bench raises a line on a level-triggered, disabled interrupt and then enables it. A design that reads only the old stored level would leave the interrupt unpended, and one that pends on every rise would pend it too early. The bench holds a line high after clearing its pending bit, and drops a line, to catch a design that treats the level as an edge. It lines up a line rise with a clear-pending write in the same cycle to check that the clear wins. It also probes offsets just past the last implemented interrupt, the wide and byte views of 0xF00, and odd bytes of the identification range, where a loose decoder would hand back data or corrupt state instead of flagging an error.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [3:0] {
    RG_CTRL, RG_TYPE, RG_ZERO, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD,
    RG_ACT, RG_PRIO, RG_TGT, RG_CFG, RG_SWTRIG, RG_IDENT, RG_BAD
  } region_e;

  // Maps an access to a register range; RG_BAD marks an error.
  function automatic region_e classify(input logic [11:0] a, input logic wr,
                                       input logic wide, input logic [9:0] d,
                                       input int nirq);
    region_e r;
    r = RG_BAD;
    if (wide) begin
      if (wr && a == 12'hF00 && int'(d) < nirq) r = RG_SWTRIG;
    end else if (a < 12'h100) begin
      if (a == 12'h000) r = RG_CTRL;
      else if (a < 12'h004) r = RG_ZERO;
      else if (a == 12'h004 && !wr) r = RG_TYPE;
      else if (a < 12'h008 && !wr) r = RG_ZERO;
    end else if (a < 12'h200) begin
      if (int'(a[6:0]) * 8 < nirq) r = a[7] ? RG_CLREN : RG_SETEN;
    end else if (a < 12'h300) begin
      if (int'(a[6:0]) * 8 < nirq) r = a[7] ? RG_CLRPD : RG_SETPD;
    end else if (a < 12'h400) begin
      if (!wr && int'(a[7:0]) * 8 < nirq) r = RG_ACT;
    end else if (a < 12'h800) begin
      if (int'(a[9:0]) < nirq) r = RG_PRIO;
    end else if (a < 12'hC00) begin
      if (int'(a[9:0]) < nirq) r = RG_TGT;
    end else if (a < 12'hF00) begin
      if (int'(a[9:0]) * 4 < nirq) r = RG_CFG;
    end else if (a >= 12'hFE0 && !wr) begin
      r = RG_IDENT;
    end
    return r;
  endfunction

  // Index of the addressed byte within its range.
  function automatic int range_index(input region_e r, input logic [11:0] a);
    case (r)
      RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD: return int'(a[6:0]);
      RG_ACT:                                 return int'(a[7:0]);
      RG_IDENT:                               return int'(a[4:2]);
      default:                                return int'(a[9:0]);
    endcase
  endfunction

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic        valid,
  input  logic        wr,
  input  logic        wide,
  input  logic [11:0] addr,
  input  logic [9:0]  wdata,
  output region_e     region,
  output logic [9:0]  index,
  output logic        err
);
  region_e rg;
  int      ix;
  always_comb begin
    rg     = classify(addr, wr, wide, wdata, NUM_IRQ);
    ix     = range_index(rg, addr);
    region = rg;
    index  = ix[9:0];
    err    = valid && (rg == RG_BAD);
  end
endmodule

// File: rtl/irq_dist_cell.sv
module irq_dist_cell #(
  parameter bit RST_ON = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_in,
  input  logic       set_en,
  input  logic       clr_en,
  input  logic       set_pd,
  input  logic       clr_pd,
  input  logic       cfg_we,
  input  logic [1:0] cfg_bits,
  input  logic       prio_we,
  input  logic       tgt_we,
  input  logic [7:0] wbyte,
  output logic       en_o,
  output logic       pd_o,
  output logic       model_o,
  output logic       edge_o,
  output logic [7:0] prio_o,
  output logic [7:0] tgt_o,
  output logic       rise_o
);
  logic lvl_q, pd_nxt, lvl_pend;

  assign rise_o   = lvl_in && !lvl_q;
  assign lvl_pend = set_en && lvl_in && !edge_o;

  always_comb begin
    pd_nxt = pd_o;
    if (rise_o && (edge_o || en_o)) pd_nxt = 1'b1;
    if (lvl_pend || set_pd)         pd_nxt = 1'b1;
    if (clr_pd)                     pd_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      pd_o    <= 1'b0;
      en_o    <= RST_ON;
      edge_o  <= RST_ON;
      model_o <= 1'b0;
      prio_o  <= '0;
      tgt_o   <= '0;
    end else begin
      lvl_q <= lvl_in;
      pd_o  <= pd_nxt;
      if (set_en)      en_o <= 1'b1;
      else if (clr_en) en_o <= 1'b0;
      if (cfg_we) begin
        model_o <= cfg_bits[0];
        edge_o  <= cfg_bits[1];
      end
      if (prio_we) prio_o <= wbyte;
      if (tgt_we)  tgt_o  <= wbyte;
    end
  end

  a_r2_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && (edge_o || en_o) && !clr_pd) |=> pd_o);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_o && !set_pd && !set_en && !clr_pd) |=> $stable(pd_o));
  a_r5_level_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && lvl_in && !edge_o && !clr_pd) |=> pd_o);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pd |=> !pd_o);
endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter int          NUM_IRQ = 96,
  parameter int          RST_ON_CNT = 15,
  parameter logic [63:0] IDENT = 64'hC35A_E107_0020_4D19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-33:0]  ext_lvl,
  input  logic [NUM_IRQ-1:0]   act_flags,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_wide,
  input  logic [11:0]          acc_addr,
  input  logic [9:0]           acc_wdata,
  output logic [7:0]           acc_rdata,
  output logic                 acc_err,
  output logic                 dist_en,
  output logic [NUM_IRQ-1:0]   irq_en,
  output logic [NUM_IRQ-1:0]   irq_pend,
  output logic [8*NUM_IRQ-1:0] irq_prio
);
  localparam int EXT_BASE = 32;
  localparam logic [7:0] TYPE_VAL = 8'(NUM_IRQ / 32 - 1);

  region_e                rg;
  logic [9:0]             idx;
  logic                   wr_ok;
  logic [NUM_IRQ-1:0]     irq_model, irq_edge, irq_rise;
  logic [8*NUM_IRQ-1:0]   irq_tgt;

  irq_dist_decode #(.NUM_IRQ(NUM_IRQ)) dec_i (
    .valid(acc_valid), .wr(acc_write), .wide(acc_wide), .addr(acc_addr),
    .wdata(acc_wdata), .region(rg), .index(idx), .err(acc_err));

  assign wr_ok = acc_valid && acc_write && !acc_err;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int BY = i / 8, BI = i % 8, CB = i / 4, CJ = i % 4;
    logic byte_hit, cfg_hit, line;
    assign byte_hit = wr_ok && (int'(idx) == BY) && acc_wdata[BI];
    assign cfg_hit  = wr_ok && (rg == RG_CFG) && (int'(idx) == CB);
    if (i >= EXT_BASE) begin : g_ext
      assign line = ext_lvl[i-EXT_BASE];
    end else begin : g_int
      assign line = 1'b0;
    end
    irq_dist_cell #(.RST_ON(i < RST_ON_CNT)) cell_i (
      .clk(clk), .rst_n(rst_n), .lvl_in(line),
      .set_en(byte_hit && rg == RG_SETEN),
      .clr_en(byte_hit && rg == RG_CLREN),
      .set_pd((byte_hit && rg == RG_SETPD) ||
              (wr_ok && rg == RG_SWTRIG && int'(acc_wdata) == i)),
      .clr_pd(byte_hit && rg == RG_CLRPD),
      .cfg_we(cfg_hit), .cfg_bits(acc_wdata[2*CJ +: 2]),
      .prio_we(wr_ok && rg == RG_PRIO && int'(idx) == i),
      .tgt_we(wr_ok && rg == RG_TGT && int'(idx) == i),
      .wbyte(acc_wdata[7:0]),
      .en_o(irq_en[i]), .pd_o(irq_pend[i]), .model_o(irq_model[i]),
      .edge_o(irq_edge[i]), .prio_o(irq_prio[8*i +: 8]),
      .tgt_o(irq_tgt[8*i +: 8]), .rise_o(irq_rise[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dist_en <= 1'b0;
    else if (wr_ok && rg == RG_CTRL) dist_en <= acc_wdata[0];
  end

  // Gathers eight bits of a per-interrupt vector for byte b.
  function automatic logic [7:0] pick8(input logic [NUM_IRQ-1:0] v, input int b);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < 8; k++)
      if (b * 8 + k < NUM_IRQ) r[k] = v[b*8 + k];
    return r;
  endfunction

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      case (rg)
        RG_CTRL:          acc_rdata = {7'd0, dist_en};
        RG_TYPE:          acc_rdata = TYPE_VAL;
        RG_SETEN, RG_CLREN: acc_rdata = pick8(irq_en, int'(idx));
        RG_SETPD, RG_CLRPD: acc_rdata = pick8(irq_pend, int'(idx));
        RG_ACT:           acc_rdata = pick8(act_flags, int'(idx));
        RG_PRIO:          acc_rdata = irq_prio[8*int'(idx) +: 8];
        RG_TGT:           acc_rdata = irq_tgt[8*int'(idx) +: 8];
        RG_CFG:
          for (int j = 0; j < 4; j++)
            if (int'(idx) * 4 + j < NUM_IRQ)
              acc_rdata[2*j +: 2] = {irq_edge[int'(idx)*4 + j],
                                     irq_model[int'(idx)*4 + j]};
        RG_IDENT:         acc_rdata = (acc_addr[1:0] == 2'b00) ?
                                      IDENT[8*int'(idx) +: 8] : 8'd0;
        default:          acc_rdata = '0;
      endcase
    end
  end

  a_r7_active_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_wide && acc_addr[11:8] == 4'h3) |-> acc_err);
  a_r14_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(irq_en));
  a_r13_err_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_err) |=> $stable(irq_en) && $stable(dist_en));
  a_r2_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise[EXT_BASE-1:0] == '0);
endmodule

// File: tb/irq_dist_bank_tb.sv
module irq_dist_bank_tb_top;
  localparam int NI = 96;
  localparam logic [63:0] ID = 64'hC35A_E107_0020_4D19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-33:0] ext_lvl = '0;
  logic [NI-1:0] act_flags = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [9:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic acc_err, dist_en;
  logic [NI-1:0] irq_en, irq_pend;
  logic [8*NI-1:0] irq_prio;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dist_bank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic wide, input logic [11:0] a,
                     input logic [9:0] d, output logic [7:0] rd, output logic e);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_addr = a; acc_wdata = d;
    #1; rd = acc_rdata; e = acc_err;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
  endtask

  task automatic wr8(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] r; logic e;
    acc(1'b1, 1'b0, a, {2'b00, d}, r, e);
  endtask

  task automatic rd8(input logic [11:0] a, output logic [7:0] r);
    logic e;
    acc(1'b0, 1'b0, a, '0, r, e);
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); ext_lvl[n] = v; @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R1 dist_en", dist_en, 0);
    chk("R1 pend", irq_pend == '0, 1);
    chk("R1 prio", irq_prio == '0, 1);
    rd8(12'h100, r); chk("R1 en 0-7", r, 8'hFF);
    rd8(12'h101, r); chk("R1 en 8-15", r, 8'h7F);
    rd8(12'h102, r); chk("R1 en 16-23", r, 8'h00);
    rd8(12'hC00, r); chk("R1 cfg 0-3", r, 8'hAA);
    rd8(12'hC03, r); chk("R1 cfg 12-15", r, 8'h2A);
  endtask

  task automatic t_ctrl;
    logic [7:0] r;
    wr8(12'h000, 8'hFF); chk("R11 dist_en", dist_en, 1);
    rd8(12'h000, r); chk("R11 ctrl read", r, 1);
    rd8(12'h004, r); chk("R11 type", r, 2);
    rd8(12'h002, r); chk("R11 zero byte", r, 0);
    wr8(12'h001, 8'h00); chk("R11 write ignored", dist_en, 1);
  endtask

  task automatic t_edges;
    logic [7:0] r;
    line(8, 1'b1); chk("R2 level disabled no pend", irq_pend[40], 0);
    line(8, 1'b0);
    wr8(12'hC0A, 8'h02); rd8(12'hC0A, r); chk("R9 cfg readback", r, 8'h02);
    line(8, 1'b1); chk("R2 edge pends irq40", irq_pend[40], 1);
    rd8(12'h205, r); chk("R2 pend read", r, 8'h01);
    wr8(12'h285, 8'h01); chk("R6 clear pend", irq_pend[40], 0);
    repeat (3) @(posedge clk); #1;
    chk("R3 held high no pend", irq_pend[40], 0);
    line(8, 1'b0); chk("R3 fall no pend", irq_pend[40], 0);
    @(negedge clk);
    ext_lvl[8] = 1'b1; acc_valid = 1'b1; acc_write = 1'b1; acc_wide = 1'b0;
    acc_addr = 12'h285; acc_wdata = 10'h001;
    @(posedge clk); #1; acc_valid = 1'b0; acc_write = 1'b0;
    chk("R6 clear beats rise", irq_pend[40], 0);
    line(28, 1'b1); chk("R2 level disabled irq60", irq_pend[60], 0);
    line(28, 1'b0);
    wr8(12'h107, 8'h10); line(28, 1'b1);
    chk("R2 enabled rise pends irq60", irq_pend[60], 1);
  endtask

  task automatic t_enable;
    logic [7:0] r;
    line(18, 1'b1); chk("R5 before enable", irq_pend[50], 0);
    wr8(12'h106, 8'h04);
    chk("R4 enable set", irq_en[50], 1);
    chk("R5 level enable pends", irq_pend[50], 1);
    rd8(12'h186, r); chk("R4 clear range reads en", r, 8'h04);
    wr8(12'h186, 8'h04); chk("R4 enable cleared", irq_en[50], 0);
    wr8(12'h100, 8'h00); rd8(12'h100, r); chk("R4 zero bits no effect", r, 8'hFF);
  endtask

  task automatic t_pending;
    logic [7:0] r;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h200; acc_wdata = 10'h081;
    #1; chk("R14 not before edge", irq_pend[7], 0);
    @(posedge clk); #1; acc_valid = 1'b0; acc_write = 1'b0;
    chk("R14 after edge", {irq_pend[7], irq_pend[0]}, 2'b11);
    rd8(12'h280, r); chk("R6 clear range reads pend", r, 8'h81);
    wr8(12'h280, 8'h01); rd8(12'h200, r); chk("R6 partial clear", r, 8'h80);
  endtask

  task automatic t_bytes;
    logic [7:0] r; logic e;
    act_flags[33] = 1'b1;
    rd8(12'h304, r); chk("R7 active read", r, 8'h02);
    acc(1'b1, 1'b0, 12'h304, 10'h0FF, r, e); chk("R7 active write err", e, 1);
    wr8(12'h42B, 8'hA5); rd8(12'h42B, r); chk("R8 prio readback", r, 8'hA5);
    chk("R8 prio output", irq_prio[8*43 +: 8], 8'hA5);
    wr8(12'h82B, 8'h03); rd8(12'h82B, r); chk("R8 target readback", r, 8'h03);
    wr8(12'hC0B, 8'h41); rd8(12'hC0B, r); chk("R9 model bits", r, 8'h41);
  endtask

  task automatic t_swtrig;
    logic [7:0] r; logic e; logic [NI-1:0] snap;
    acc(1'b1, 1'b1, 12'hF00, 10'd85, r, e);
    chk("R10 no err", e, 0); chk("R10 sets irq85", irq_pend[85], 1);
    snap = irq_pend;
    acc(1'b1, 1'b1, 12'hF00, 10'h3FF, r, e);
    chk("R10 big id err", e, 1); chk("R10 big id no change", irq_pend == snap, 1);
  endtask

  task automatic t_ident;
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      rd8(12'hFE0 + 12'(4*k), r); chk("R12 ident byte", r, ID[8*k +: 8]);
    end
    rd8(12'hFE1, r); chk("R12 odd byte zero", r, 0);
  endtask

  task automatic t_bad;
    logic [7:0] r; logic e; logic [NI-1:0] sp, se;
    sp = irq_pend; se = irq_en;
    acc(1'b0, 1'b0, 12'h008, '0, r, e); chk("R13 read 0x008", e, 1);
    acc(1'b1, 1'b0, 12'h004, '0, r, e); chk("R13 write 0x004", e, 1);
    acc(1'b0, 1'b0, 12'h10C, '0, r, e); chk("R13 enable past end", e, 1);
    acc(1'b1, 1'b0, 12'h10C, 10'h0FF, r, e); chk("R13 enable write past end", e, 1);
    acc(1'b1, 1'b0, 12'hF00, 10'd3, r, e); chk("R13 byte swtrig", e, 1);
    acc(1'b0, 1'b0, 12'hF10, '0, r, e); chk("R13 gap read", e, 1);
    acc(1'b1, 1'b0, 12'hFE0, 10'h0FF, r, e); chk("R13 ident write", e, 1);
    acc(1'b0, 1'b1, 12'h100, '0, r, e); chk("R13 wide read", e, 1);
    chk("R13 no state change", {irq_pend == sp, irq_en == se}, 2'b11);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset; t_ctrl; t_edges; t_enable; t_pending; t_bytes; t_swtrig; t_ident; t_bad;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule